// File: doc/BRIEF.md
# Parallel Video-Word CRC16 Accumulator

This block keeps a running 16-bit CRC over a stream of 10-bit video samples. It takes in one whole sample on every clock cycle in which it is enabled and told to accumulate. The generator polynomial is x^16 + x^12 + x^5 + 1. Within each sample, bit 0 enters the CRC first and bit 9 enters it last. Next-state logic folds all ten bits in one cycle, and the result equals ten serial shifts.

Each sample passes a clipping stage before it reaches the CRC. If the eight upper bits are all ones, the two lowest bits are replaced with ones. The register can be cleared synchronously, and clear wins over accumulate. The surrounding logic decides which samples belong to a CRC interval and drives the accumulate strobe to match. The register contents appear directly on the output, with no final inversion and no bit reversal.

Top module: `vidword_crc16`

## Requirements
- R1: An active-high `rst` sets `crc_o` to 0x0000 immediately, without waiting for a clock edge.
- R2: While `ce_i` is low, `crc_o` keeps its value across clock edges, whatever `clr_i`, `acc_i` and `smp_i` are.
- R3: On a clock edge with `ce_i` and `clr_i` both high, `crc_o` becomes 0x0000, even when `acc_i` is also high.
- R4: On a clock edge with `ce_i` and `acc_i` high and `clr_i` low, `crc_o` takes the result of ten serial steps on the clipped sample w. The steps run for i = 0 to 9 in that order. Each step forms fb = crc[15] XOR w[i], shifts crc left by one with a 0 into bit 0, and XORs 0x1021 into crc when fb is 1.
- R5: On a clock edge with `ce_i` high and both `clr_i` and `acc_i` low, `crc_o` keeps its value.
- R6: A sample whose bits 9..2 are all ones (0x3FC to 0x3FF) enters the CRC as 0x3FF, so all four of these values give the same CRC.
- R7: Any other sample enters the CRC unchanged, so for example 0x3FB and 0x1FC each give their own distinct CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| ce_i | input | 1 | Clock enable |
| clr_i | input | 1 | Synchronous clear; has priority over accumulate |
| acc_i | input | 1 | Fold the current sample into the CRC |
| smp_i | input | DATA_W (10) | Video sample |
| crc_o | output | CRC_W (16) | Current CRC register contents |

## Verification
The bench builds the block with its default parameters: 10-bit samples, a 16-bit CRC and the 0x1021 polynomial. Because the sample is only 10 bits wide, the bench can sweep all 1024 sample values from a cleared register. It compares each result with a bit-serial model in the bench, so every pattern of the clip condition and every feedback pattern of the ten-step fold is checked. Random multi-word sequences with random enable, clear and accumulate strobes then cover the carry of CRC state from one word to the next, the priority of clear over accumulate, and the hold behaviour.

// File: rtl/vcrc_pkg.sv
package vcrc_pkg;
  localparam int unsigned VCRC_DATA_W = 10;
  localparam int unsigned VCRC_CRC_W  = 16;
  localparam int unsigned VCRC_LOW_W  = 2;
  localparam logic [15:0] VCRC_POLY   = 16'h1021;

  typedef enum logic [1:0] {
    VCRC_HOLD  = 2'd0,
    VCRC_CLEAR = 2'd1,
    VCRC_FOLD  = 2'd2
  } vcrc_act_e;
endpackage

// File: rtl/vcrc_clip.sv
module vcrc_clip #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned LOW_W  = 2
) (
  input  logic [DATA_W-1:0] smp_i,
  output logic [DATA_W-1:0] smp_o
);
  localparam int unsigned HIGH_W = DATA_W - LOW_W;

  logic [HIGH_W-1:0] high_part;
  logic [LOW_W-1:0]  low_part;
  logic              near_full;

  assign high_part = smp_i[DATA_W-1:LOW_W];
  assign low_part  = smp_i[LOW_W-1:0];
  assign near_full = &high_part;

  always_comb begin
    smp_o = {high_part, low_part};
    if (near_full) smp_o[LOW_W-1:0] = '1;
  end
endmodule

// File: rtl/vcrc_fold.sv
module vcrc_fold #(
  parameter int unsigned       DATA_W = 10,
  parameter int unsigned       CRC_W  = 16,
  parameter logic [CRC_W-1:0]  POLY   = 16'h1021
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [0:DATA_W];

  assign stage[0] = crc_i;

  // One serial step per data bit, bit 0 first.
  for (genvar g = 0; g < DATA_W; g++) begin : g_step
    logic fb;
    assign fb = stage[g][CRC_W-1] ^ dat_i[g];
    assign stage[g+1] = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : {CRC_W{1'b0}});
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/vcrc_state.sv
module vcrc_state
  import vcrc_pkg::*;
#(
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_i,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic [CRC_W-1:0] nxt_i,
  output logic [CRC_W-1:0] crc_o
);
  vcrc_act_e        act;
  logic [CRC_W-1:0] crc_q;

  always_comb begin
    act = VCRC_HOLD;
    if (ce_i) begin
      if (clr_i)      act = VCRC_CLEAR;
      else if (acc_i) act = VCRC_FOLD;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      crc_q <= '0;
    end else begin
      case (act)
        VCRC_CLEAR: crc_q <= '0;
        VCRC_FOLD:  crc_q <= nxt_i;
        default:    crc_q <= crc_q;
      endcase
    end
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/vidword_crc16.sv
module vidword_crc16
  import vcrc_pkg::*;
#(
  parameter int unsigned      DATA_W = VCRC_DATA_W,
  parameter int unsigned      CRC_W  = VCRC_CRC_W,
  parameter int unsigned      LOW_W  = VCRC_LOW_W,
  parameter logic [CRC_W-1:0] POLY   = VCRC_POLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_i,
  input  logic              clr_i,
  input  logic              acc_i,
  input  logic [DATA_W-1:0] smp_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [DATA_W-1:0] smp_clipped;
  logic [CRC_W-1:0]  crc_nxt;
  logic [CRC_W-1:0]  crc_cur;

  vcrc_clip #(.DATA_W(DATA_W), .LOW_W(LOW_W)) clip_i (
    .smp_i (smp_i),
    .smp_o (smp_clipped)
  );

  vcrc_fold #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) fold_i (
    .crc_i (crc_cur),
    .dat_i (smp_clipped),
    .crc_o (crc_nxt)
  );

  vcrc_state #(.CRC_W(CRC_W)) state_i (
    .clk   (clk),
    .rst   (rst),
    .ce_i  (ce_i),
    .clr_i (clr_i),
    .acc_i (acc_i),
    .nxt_i (crc_nxt),
    .crc_o (crc_cur)
  );

  assign crc_o = crc_cur;
endmodule

// File: rtl/vidword_crc16_chk.sv
module vidword_crc16_chk #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned LOW_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_i,
  input logic              clr_i,
  input logic              acc_i,
  input logic [DATA_W-1:0] smp_i,
  input logic [DATA_W-1:0] clipped,
  input logic [CRC_W-1:0]  nxt,
  input logic [CRC_W-1:0]  crc
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    $fell(rst) |-> crc == '0);

  assert_enable_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ce_i |=> $stable(crc));

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (ce_i && clr_i) |=> crc == '0);

  assert_fold_load_R4: assert property (@(posedge clk) disable iff (rst)
    (ce_i && !clr_i && acc_i) |=> crc == $past(nxt));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ce_i && !clr_i && !acc_i) |=> $stable(crc));

  assert_clip_force_R6: assert property (@(posedge clk) disable iff (rst)
    (&smp_i[DATA_W-1:LOW_W]) |-> (&clipped));

  assert_pass_through_R7: assert property (@(posedge clk) disable iff (rst)
    !(&smp_i[DATA_W-1:LOW_W]) |-> clipped == smp_i);
endmodule

bind vidword_crc16 vidword_crc16_chk #(
  .DATA_W(DATA_W), .CRC_W(CRC_W), .LOW_W(LOW_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .ce_i    (ce_i),
  .clr_i   (clr_i),
  .acc_i   (acc_i),
  .smp_i   (smp_i),
  .clipped (smp_clipped),
  .nxt     (crc_nxt),
  .crc     (crc_o)
);

// File: tb/vidword_crc16_tb_top.sv
`timescale 1ns/1ps
module vidword_crc16_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0, clr = 1'b0, acc = 1'b0;
  logic [9:0]  smp = '0;
  logic [15:0] crc;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  vidword_crc16 dut_i (
    .clk(clk), .rst(rst), .ce_i(ce), .clr_i(clr), .acc_i(acc),
    .smp_i(smp), .crc_o(crc)
  );

  function automatic logic [9:0] clip_ref(input logic [9:0] v);
    return (v >= 10'h3FC) ? 10'h3FF : v;
  endfunction

  function automatic logic [15:0] serial_ref(input logic [15:0] c, input logic [9:0] w);
    logic [15:0] r = c;
    for (int i = 0; i < 10; i++) begin
      logic fb = r[15] ^ w[i];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_run++;
    if (crc !== exp) begin
      n_fail++;
      $display("FAIL %s: crc=%h expected=%h", req, crc, exp);
    end
  endtask

  // Drive at negedge; the register updates at the following posedge,
  // and the result is sampled at the next negedge.
  task automatic step(input logic e, input logic c, input logic a, input logic [9:0] v);
    ce = e; clr = c; acc = a; smp = v;
    @(negedge clk);
  endtask

  logic [15:0] model;
  logic [15:0] crc_a, crc_b;

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);
    rst = 1'b0;
    @(negedge clk);

    // R4/R6/R7: exhaustive single-word sweep from a cleared register
    for (int v = 0; v < 1024; v++) begin
      step(1, 1, 0, 10'h000);
      step(1, 0, 1, v[9:0]);
      check(v >= 1020 ? "R6" : "R4", serial_ref(16'h0000, clip_ref(v[9:0])));
    end

    // R6: all near-full values give one CRC
    step(1, 1, 0, 0); step(1, 0, 1, 10'h3FC); crc_a = crc;
    step(1, 1, 0, 0); step(1, 0, 1, 10'h3FF); crc_b = crc;
    n_run++;
    if (crc_a !== crc_b) begin
      n_fail++; $display("FAIL R6: 3FC->%h 3FF->%h expected equal", crc_a, crc_b);
    end
    // R7: 0x3FB and 0x1FC are not clipped
    step(1, 1, 0, 0); step(1, 0, 1, 10'h3FB);
    check("R7", serial_ref(16'h0000, 10'h3FB));
    step(1, 1, 0, 0); step(1, 0, 1, 10'h1FC);
    check("R7", serial_ref(16'h0000, 10'h1FC));

    // R3: clear wins over accumulate
    step(1, 0, 1, 10'h155);
    step(1, 1, 1, 10'h2AA);
    check("R3", 16'h0000);

    // R2 / R5 directed holds
    step(1, 0, 1, 10'h0F3); model = serial_ref(16'h0000, 10'h0F3);
    step(0, 1, 1, 10'h3FF);
    check("R2", model);
    step(1, 0, 0, 10'h123);
    check("R5", model);

    // Random multi-word sequences
    model = crc;
    for (int s = 0; s < 40; s++) begin
      for (int k = 0; k < 64; k++) begin
        logic e = ($urandom % 8) != 0;
        logic c = ($urandom % 32) == 0;
        logic a = ($urandom % 4) != 0;
        logic [9:0] v = ($urandom % 4 == 0) ? (10'h3FC | 10'($urandom % 4)) : 10'($urandom);
        step(e, c, a, v);
        if (e && c)      model = 16'h0000;
        else if (e && a) model = serial_ref(model, clip_ref(v));
        check(!e ? "R2" : c ? "R3" : a ? "R4" : "R5", model);
      end
    end

    // R1: asynchronous reset mid-stream
    step(1, 0, 1, 10'h2C7);
    #1 rst = 1'b1;
    #0.5;
    check("R1", 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule